// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Converter with Internal Loopback

This block turns 10-bit line-coded characters, presented on a parallel bus alongside a byte clock, into a serial bit stream that leaves the block least significant bit first. The byte clock is treated as an ordinary data-rate signal sampled by the core clock. A rate control decides which byte-clock transitions capture a word. In full rate, both transitions capture a word, so two words are taken per byte-clock period and the line carries twenty bits per period. In half rate, only the high-to-low transition captures a word.

Bit timing comes from a single-cycle enable, the bit tick. Each tick advances the line by one bit. A captured word waits in a one-word holding register until the word being sent has finished, and then starts on the next tick. When nothing is waiting, the line rests at logic one. A loopback control parks the external serial pin at logic one and hands the internal stream to the receive-side input select in place of the external serial input.

Top module: `dser_top`

## Requirements
- R1: After reset, before any word has been captured, `ser_o` is 1 and `rx_bit_o` follows `ext_rx_i` (loopback off).
- R2: A word is sent as ten consecutive bits, one per bit tick, with bit 0 first and bit 9 last.
- R3: With `full_rate_i`=1, the word on `word_i` is captured on every change of `bclk_i`, whether it rises or falls.
- R4: With `full_rate_i`=0, a word is captured only when `bclk_i` falls; words offered at a rising edge are never sent.
- R5: A captured word begins only after the previous word's tenth bit. When a word is waiting at that point, it follows with no idle bit between.
- R6: The serial line changes only on cycles where `bit_tick_i` is 1; it holds its value otherwise.
- R7: While `loop_en_i`=1, `ser_o` is 1 regardless of the stream.
- R8: While `loop_en_i`=1, `rx_bit_o` carries the internal stream; while it is 0, `rx_bit_o` equals `ext_rx_i`.
- R9: When no word is being sent and none is waiting, the internal stream and `ser_o` (loopback off) are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_rate_i | input | 1 | 1: capture on both byte-clock edges; 0: falling edge only |
| loop_en_i | input | 1 | 1: park serial pin high and loop stream to receive side |
| bclk_i | input | 1 | Byte clock, sampled by `clk` |
| word_i | input | WORD_W | Parallel character, bit 0 sent first |
| bit_tick_i | input | 1 | One-cycle enable marking a bit time |
| ext_rx_i | input | 1 | External serial input to the receive side |
| ser_o | output | 1 | External serial output |
| rx_bit_o | output | 1 | Serial bit selected for the receive side |

## Verification
The bench builds the block with its default 10-bit word. A scoreboard pushes each expected character's bits in order and compares them at every tick. With a continuous tick and a byte-clock half period of exactly ten cycles, each word ends on the cycle before its successor loads, which exercises back-to-back handover. A tick on every third cycle exercises holding between ticks and a word that waits for the next tick. The half-rate phase offers distinct words at rising edges, and these must never reach the line.

// File: rtl/dser_pkg.sv
package dser_pkg;

  // Whether a byte-clock transition captures a word for the given rate mode.
  function automatic logic take_edge(input logic full, input logic rise, input logic fall);
    return fall | (full & rise);
  endfunction

  // Level presented on the line: current bit while active, idle high otherwise.
  function automatic logic line_level(input logic active, input logic lsb);
    return active ? lsb : 1'b1;
  endfunction

endpackage

// File: rtl/dser_capture.sv
module dser_capture #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              full_rate_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] cap_word_o,
  output logic              pend_o
);
  import dser_pkg::*;

  logic bclk_q;
  logic rise_evt;
  logic fall_evt;
  logic cap_evt;

  assign rise_evt = bclk_i & ~bclk_q;
  assign fall_evt = ~bclk_i & bclk_q;
  assign cap_evt  = take_edge(full_rate_i, rise_evt, fall_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      cap_word_o <= '1;
      pend_o     <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (cap_evt) begin
        cap_word_o <= word_i;
        pend_o     <= 1'b1;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
    end
  end

  // R3: a capture always leaves a word waiting
  p_cap_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> pend_o);

  // R4: a rising edge in half rate leaves the holding register untouched
  p_half_skip_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rate_i && rise_evt) |=> $stable(cap_word_o));

  // R5: the waiting flag only drops when the shifter took the word
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(take_i));

endmodule

// File: rtl/dser_shift.sv
module dser_shift #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic              pend_i,
  input  logic [WORD_W-1:0] cap_word_i,
  output logic              take_o,
  output logic              stream_o
);
  import dser_pkg::*;

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic              last_bit;

  assign last_bit = (cnt_q == LAST_IDX);
  assign take_o   = bit_tick_i & pend_i & (~act_q | last_bit);
  assign stream_o = line_level(act_q, sh_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (bit_tick_i) begin
      if (take_o) begin
        sh_q  <= cap_word_i;
        cnt_q <= '0;
        act_q <= 1'b1;
      end else if (act_q && !last_bit) begin
        sh_q  <= {1'b1, sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  // R2: a load restarts the bit index at the first bit
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (act_q && cnt_q == '0));

  // R5: no word starts while the current one still has bits to send
  p_no_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_bit) |-> !take_o);

  // R6: the stream holds between ticks
  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick_i |=> $stable(stream_o));

  // R2: the bit index never runs past the word
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);

endmodule

// File: rtl/dser_route.sv
module dser_route (
  input  logic loop_en_i,
  input  logic stream_i,
  input  logic ext_rx_i,
  output logic ser_o,
  output logic rx_bit_o
);
  assign ser_o    = loop_en_i ? 1'b1 : stream_i;
  assign rx_bit_o = loop_en_i ? stream_i : ext_rx_i;
endmodule

// File: rtl/dser_top.sv
module dser_top #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rate_i,
  input  logic              loop_en_i,
  input  logic              bclk_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              bit_tick_i,
  input  logic              ext_rx_i,
  output logic              ser_o,
  output logic              rx_bit_o
);

  logic [WORD_W-1:0] cap_word;
  logic              pend;
  logic              take;
  logic              stream;

  dser_capture #(.WORD_W(WORD_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_i     (bclk_i),
    .full_rate_i(full_rate_i),
    .word_i     (word_i),
    .take_i     (take),
    .cap_word_o (cap_word),
    .pend_o     (pend)
  );

  dser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick_i (bit_tick_i),
    .pend_i     (pend),
    .cap_word_i (cap_word),
    .take_o     (take),
    .stream_o   (stream)
  );

  dser_route u_route (
    .loop_en_i(loop_en_i),
    .stream_i (stream),
    .ext_rx_i (ext_rx_i),
    .ser_o    (ser_o),
    .rx_bit_o (rx_bit_o)
  );

  // R7: the pin stays parked across consecutive loopback cycles
  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en_i && $past(loop_en_i)) |-> (ser_o && $stable(ser_o)));

endmodule

// File: tb/dser_top_tb_top.sv
module dser_top_tb_top;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         full_rate_i = 1'b1;
  logic         loop_en_i = 1'b0;
  logic         bclk_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         bit_tick_i = 1'b1;
  logic         ext_rx_i = 1'b0;
  logic         ser_o;
  logic         rx_bit_o;

  int    total = 0;
  int    bad = 0;
  int    tick_div = 1;
  bit    finished = 1'b0;
  string req_tag = "R1";
  logic  expq[$];

  always #10 clk = ~clk;

  dser_top #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_rate_i(full_rate_i), .loop_en_i(loop_en_i),
    .bclk_i(bclk_i), .word_i(word_i), .bit_tick_i(bit_tick_i), .ext_rx_i(ext_rx_i),
    .ser_o(ser_o), .rx_bit_o(rx_bit_o)
  );

  // tick and external-input drivers
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      bit_tick_i = ((n % tick_div) == 0);
      ext_rx_i   = n[1] ^ n[3];
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: pops one expected bit per tick, compares every cycle
  initial begin
    logic cur = 1'b1;
    forever begin
      logic tk;
      @(posedge clk);
      tk = bit_tick_i;
      #2;
      if (!rst_n) begin
        cur = 1'b1;
      end else begin
        if (tk) cur = (expq.size() > 0) ? expq.pop_front() : 1'b1;
        // R2 R3 R5 R6 R9 via stream; R7 parking; R8 routing
        check(req_tag, "ser_o", ser_o, loop_en_i ? 1'b1 : cur);
        check(loop_en_i ? "R8" : req_tag, "rx_bit_o", rx_bit_o, loop_en_i ? cur : ext_rx_i);
      end
    end
  end

  // driver: make a byte-clock transition, optionally expect the word
  task automatic bedge(input logic lvl, input logic [W-1:0] w, input bit expect_it, input int hold);
    @(negedge clk);
    word_i = w;
    bclk_i = lvl;
    @(posedge clk);
    #5;
    if (expect_it) for (int i = 0; i < W; i++) expq.push_back(w[i]);
    repeat (hold - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    req_tag = "R1";
    repeat (6) @(negedge clk);

    // R3 R2 R5: full rate, both edges, back-to-back words
    req_tag = "R3";
    bedge(1'b1, 10'h17C, 1'b1, 10);
    bedge(1'b0, 10'h283, 1'b1, 10);
    bedge(1'b1, 10'h001, 1'b1, 10);
    bedge(1'b0, 10'h200, 1'b1, 10);
    bedge(1'b1, 10'h2AA, 1'b1, 10);
    bedge(1'b0, 10'h0F3, 1'b1, 10);
    // R9: idle high after the stream drains
    req_tag = "R9";
    repeat (15) @(negedge clk);

    // R4: half rate, rising-edge words must never appear
    full_rate_i = 1'b0;
    req_tag = "R4";
    bedge(1'b1, 10'h3FF, 1'b0, 12);
    bedge(1'b0, 10'h155, 1'b1, 12);
    bedge(1'b1, 10'h000, 1'b0, 12);
    bedge(1'b0, 10'h31C, 1'b1, 12);
    repeat (12) @(negedge clk);

    // R6: sparse ticks, line holds between them
    full_rate_i = 1'b1;
    tick_div = 3;
    req_tag = "R6";
    bedge(1'b1, 10'h0C7, 1'b1, 35);
    bedge(1'b0, 10'h338, 1'b1, 35);
    repeat (10) @(negedge clk);
    tick_div = 1;
    repeat (5) @(negedge clk);

    // R7 R8: loopback, toggled mid-stream
    loop_en_i = 1'b1;
    req_tag = "R7";
    bedge(1'b1, 10'h1E5, 1'b1, 10);
    bedge(1'b0, 10'h0B6, 1'b1, 4);
    loop_en_i = 1'b0;
    req_tag = "R8";
    repeat (4) @(negedge clk);
    loop_en_i = 1'b1;
    repeat (20) @(negedge clk);
    loop_en_i = 1'b0;
    repeat (5) @(negedge clk);

    // R5: every expected bit has been emitted
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R5 leftover bits act=%0d exp=0", expq.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule